// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This peripheral keeps wall-clock time as a plain 32-bit count of seconds. A slow reference clock (nominally 32.768 kHz) drives a programmable prescaler. The prescaler issues one tick per second, and each tick adds one to the seconds counter. Software can set a 32-bit alarm value. When the counter reaches that value, an event flag is raised. A second flag records every tick.

Each flag has its own enable bit. An interrupt line is asserted only while a flag and its enable are both set. The flags are cleared by writing ones to them. A small synchronous register bus reads and writes the time, the alarm value, the prescaler setting and the status word. Read data is returned in the same cycle as the request.

The prescaler has a fractional correction. A trim value lengthens a chosen number of tick periods by one reference cycle. A prescaler register that holds all zeros selects a built-in default, so a block fresh out of reset still produces a one-second tick.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset, the alarm, counter, prescaler and status registers all read zero, and both interrupt outputs are low.
- R2: While the whole prescaler register is zero, a tick occurs every DEF_DIV+1 = 32768 clock cycles.
- R3: A nonzero divider D in prescaler bits 15:0, with trim zero, gives a tick every D+1 cycles, and the counter advances by one per tick. Prescaler bits 31:24 are not stored and read as zero. Any write to the prescaler restarts the tick period and the trim schedule.
- R4: A trim value T in prescaler bits 23:16 makes the first T ticks of every group of 256 take D+2 cycles, with ticks counted from the last prescaler write. The remaining ticks in the group take D+1 cycles.
- R5: A bus write to the counter loads the written value. It wins over a tick in the same cycle and leaves the tick timing untouched.
- R6: The alarm flag (status bit 0) sets one cycle after a counter update (a tick or a write) leaves the counter equal to the alarm value. It sets whatever its enable says. Writing the alarm register alone never sets it, and it does not set again while the counter stays equal without a further update.
- R7: The tick flag (status bit 1) sets on every tick, whatever its enable says.
- R8: Writing a one to status bit 0 or bit 1 clears that flag, and writing a zero leaves it unchanged. If a flag sets and is cleared in the same cycle, it stays set.
- R9: Status bit 2 (alarm enable) and bit 3 (tick enable) are plain read/write bits. The output irq_alarm equals bit 0 AND bit 2, and irq_tick equals bit 1 AND bit 3.
- R10: With ALT_MAP=0 the offsets are alarm 0x00, counter 0x04, prescaler 0x08 and status 0x10. With ALT_MAP=1 they are counter 0x00, alarm 0x04, status 0x08 and prescaler 0x0C. Unmapped offsets read zero and ignore writes. bus_rdata is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (32.768 kHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the request |
| irq_alarm | output | 1 | Alarm interrupt (flag AND enable) |
| irq_tick | output | 1 | Per-second interrupt (flag AND enable) |

## Verification
A prescaler that has slipped or wrapped late shows up at the ports as a seconds counter that changes on the wrong cycle. The bench therefore counts the exact number of cycles between counter changes, including periods stretched by trim.

A compare that is missing or is level-driven shows up at status bit 0 in the same way. The flag appears early, appears late, or comes back after being cleared, and this is visible within one or two cycles of the counter update.

Mistakes in flag priority or in the address decode show up at once on the next combinational read of the status word or of the register concerned.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // status word bit positions
  localparam int FLAG_AL = 0;
  localparam int FLAG_HZ = 1;
  localparam int EN_AL   = 2;
  localparam int EN_HZ   = 3;
  localparam int STAT_W  = 4;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_ALARM,
    REG_COUNT,
    REG_DIVTRIM,
    REG_STATUS
  } reg_id_e;

  // byte offset -> register, for either of the two layouts
  function automatic reg_id_e map_offset(input logic alt, input logic [7:0] off);
    reg_id_e id;
    id = REG_NONE;
    if (!alt) begin
      case (off)
        8'h00:   id = REG_ALARM;
        8'h04:   id = REG_COUNT;
        8'h08:   id = REG_DIVTRIM;
        8'h10:   id = REG_STATUS;
        default: id = REG_NONE;
      endcase
    end else begin
      case (off)
        8'h00:   id = REG_COUNT;
        8'h04:   id = REG_ALARM;
        8'h08:   id = REG_STATUS;
        8'h0C:   id = REG_DIVTRIM;
        default: id = REG_NONE;
      endcase
    end
    return id;
  endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int DIV_W   = 16,
  parameter int TRIM_W  = 8,
  parameter int DEF_DIV = 32767
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              cfg_zero,
  input  logic [DIV_W-1:0]  div_val,
  input  logic [TRIM_W-1:0] trim_val,
  output logic              tick
);

  localparam int CNT_W = DIV_W + 1;
  localparam logic [DIV_W-1:0] DEF_VAL = DIV_W'(DEF_DIV);

  // last count value of a period: divider, plus one when this period is stretched
  function automatic logic [CNT_W-1:0] wrap_point(input logic [DIV_W-1:0] d,
                                                   input logic stretch_en);
    return {1'b0, d} + CNT_W'(stretch_en);
  endfunction

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  limit;
  logic [TRIM_W-1:0] phase_q;
  logic [DIV_W-1:0]  eff_div;
  logic              stretch;

  always_comb begin
    eff_div = cfg_zero ? DEF_VAL : div_val;
    stretch = (phase_q < trim_val);
    limit   = wrap_point(eff_div, stretch);
  end

  assign tick = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (restart) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (tick) begin
      cnt_q   <= '0;
      phase_q <= phase_q + 1'b1;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // count never runs past the wrap point of the current period
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  // a tick always starts a fresh period from zero
  assert_tick_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

  // trim schedule advances by exactly one step per tick
  assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> (phase_q == $past(phase_q) + 1'b1));

endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_al,
  input  logic              set_hz,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_bits,
  output logic [STAT_W-1:0] status,
  output logic              irq_al,
  output logic              irq_hz
);

  logic al_q, hz_q, al_en_q, hz_en_q;
  logic clr_al, clr_hz;

  assign clr_al = wr_en & wr_bits[FLAG_AL];
  assign clr_hz = wr_en & wr_bits[FLAG_HZ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q    <= 1'b0;
      hz_q    <= 1'b0;
      al_en_q <= 1'b0;
      hz_en_q <= 1'b0;
    end else begin
      al_q <= set_al | (al_q & ~clr_al);
      hz_q <= set_hz | (hz_q & ~clr_hz);
      if (wr_en) begin
        al_en_q <= wr_bits[EN_AL];
        hz_en_q <= wr_bits[EN_HZ];
      end
    end
  end

  always_comb begin
    status          = '0;
    status[FLAG_AL] = al_q;
    status[FLAG_HZ] = hz_q;
    status[EN_AL]   = al_en_q;
    status[EN_HZ]   = hz_en_q;
  end

  assign irq_al = al_q & al_en_q;
  assign irq_hz = hz_q & hz_en_q;

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_al || set_hz) |=> ((!$past(set_al) || al_q) && (!$past(set_hz) || hz_q)));

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_al && !set_al) |=> !al_q);

  assert_zero_write_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_bits[FLAG_HZ] && hz_q) |=> hz_q);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!al_en_q |-> !irq_al) and (!hz_en_q |-> !irq_hz));

endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DIV_W   = 16,
  parameter int TRIM_W  = 8,
  parameter int DEF_DIV = 32767,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_alarm,
  output logic              irq_tick
);

  localparam int CFG_W = DIV_W + TRIM_W;

  reg_id_e           reg_id;
  logic              wr_alarm, wr_count, wr_cfg, wr_stat;
  logic [CFG_W-1:0]  cfg_q;
  logic [31:0]       count_q;
  logic [31:0]       alarm_q;
  logic              cnt_upd_q;
  logic              tick;
  logic              alarm_hit;
  logic [STAT_W-1:0] status;

  assign reg_id   = map_offset(ALT_MAP, 8'(bus_addr));
  assign wr_alarm = bus_sel & bus_we & (reg_id == REG_ALARM);
  assign wr_count = bus_sel & bus_we & (reg_id == REG_COUNT);
  assign wr_cfg   = bus_sel & bus_we & (reg_id == REG_DIVTRIM);
  assign wr_stat  = bus_sel & bus_we & (reg_id == REG_STATUS);

  rtc_tick_gen #(
    .DIV_W  (DIV_W),
    .TRIM_W (TRIM_W),
    .DEF_DIV(DEF_DIV)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_cfg),
    .cfg_zero(cfg_q == '0),
    .div_val (cfg_q[DIV_W-1:0]),
    .trim_val(cfg_q[CFG_W-1:DIV_W]),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      count_q   <= '0;
      alarm_q   <= '0;
      cnt_upd_q <= 1'b0;
    end else begin
      if (wr_cfg)   cfg_q   <= bus_wdata[CFG_W-1:0];
      if (wr_alarm) alarm_q <= bus_wdata;
      if (wr_count)  count_q <= bus_wdata;
      else if (tick) count_q <= count_q + 32'd1;
      cnt_upd_q <= tick | wr_count;
    end
  end

  // compare only on the cycle after the counter changed
  assign alarm_hit = cnt_upd_q & (count_q == alarm_q);

  rtc_status_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_al (alarm_hit),
    .set_hz (tick),
    .wr_en  (wr_stat),
    .wr_bits(bus_wdata[STAT_W-1:0]),
    .status (status),
    .irq_al (irq_alarm),
    .irq_hz (irq_tick)
  );

  always_comb begin
    case (reg_id)
      REG_ALARM:   bus_rdata = alarm_q;
      REG_COUNT:   bus_rdata = count_q;
      REG_DIVTRIM: bus_rdata = 32'(cfg_q);
      REG_STATUS:  bus_rdata = 32'(status);
      default:     bus_rdata = '0;
    endcase
  end

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_count) |=> (count_q == $past(count_q) + 32'd1));

  assert_count_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (count_q == $past(bus_wdata)));

  assert_alarm_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> status[FLAG_AL]);

  assert_alarm_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_upd_q && !status[FLAG_AL]) |=> !status[FLAG_AL]);

  assert_tick_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> status[FLAG_HZ]);

endmodule

// File: tb/rtc_alarm_core_bench.sv
module rtc_alarm_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 5;
  localparam int WATCHDOG   = 190000;
  localparam int NVEC       = 15;

  // {we, addr[7:0], wdata[31:0], expected read[31:0]}
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 32'h1234_5678, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'h1234_5678},
    {1'b1, 8'h04, 32'hCAFE_0000, 32'h0},
    {1'b0, 8'h04, 32'h0,         32'hCAFE_0000},
    {1'b0, 8'h10, 32'h0,         32'h0},
    {1'b1, 8'h10, 32'h0000_000C, 32'h0},
    {1'b0, 8'h10, 32'h0,         32'h0000_000C},
    {1'b1, 8'h10, 32'h0000_0003, 32'h0},
    {1'b0, 8'h10, 32'h0,         32'h0},
    {1'b1, 8'h0C, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 8'h0C, 32'h0,         32'h0},
    {1'b0, 8'h08, 32'h0,         32'h0},
    {1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'h1234_5678},
    {1'b0, 8'h04, 32'h0,         32'hCAFE_0000}
  };

  logic              clk;
  logic              rst_n;
  logic              sel_main, sel_alt, we;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata_main, rdata_alt;
  logic              irq_al_main, irq_hz_main, irq_al_alt, irq_hz_alt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rtc_alarm_core #(.ALT_MAP(1'b0)) u_rtc_alarm_core (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_main), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_main), .irq_alarm(irq_al_main), .irq_tick(irq_hz_main)
  );

  rtc_alarm_core #(.ALT_MAP(1'b1)) u_rtc_alarm_core_alt (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_alt), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_alt), .irq_alarm(irq_al_alt), .irq_tick(irq_hz_alt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called in the low clock phase; the write lands on the next rising edge
  task automatic bus_write(input bit alt, input logic [7:0] a, input logic [31:0] d);
    if (alt) sel_alt = 1'b1; else sel_main = 1'b1;
    we = 1'b1; addr = a[ADDR_W-1:0]; wdata = d;
    @(negedge clk);
    sel_main = 1'b0; sel_alt = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input bit alt, input logic [7:0] a, output logic [31:0] d);
    if (alt) sel_alt = 1'b1; else sel_main = 1'b1;
    we = 1'b0; addr = a[ADDR_W-1:0];
    #1;
    d = alt ? rdata_alt : rdata_main;
    sel_main = 1'b0; sel_alt = 1'b0;
  endtask

  // cycles until the counter changes; returns the new value
  task automatic measure_period(output int n, output logic [31:0] v);
    logic [31:0] start;
    sel_main = 1'b1; we = 1'b0; addr = 5'h04;
    #1;
    start = rdata_main; n = 0; v = start;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk); #1;
      n++;
      if (rdata_main !== start) begin
        v = rdata_main;
        break;
      end
    end
    sel_main = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] r, v, c;
    rst_n = 1'b0; sel_main = 1'b0; sel_alt = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(0, 8'h00, r); chk("R1 alarm", r, 32'h0);
    bus_read(0, 8'h04, r); chk("R1 counter", r, 32'h0);
    bus_read(0, 8'h08, r); chk("R1 prescaler", r, 32'h0);
    bus_read(0, 8'h10, r); chk("R1 status", r, 32'h0);
    chk("R1 irqs", {30'h0, irq_al_main, irq_hz_main}, 32'h0);
    @(negedge clk);

    // R10 / R9 register table
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][72]) bus_write(0, VEC[i][71:64], VEC[i][63:32]);
      else begin
        bus_read(0, VEC[i][71:64], r);
        chk($sformatf("R10 table entry %0d", i), r, VEC[i][31:0]);
        @(negedge clk);
      end
    end

    // R2 default prescaler
    bus_write(0, 8'h08, 32'h0);
    measure_period(n, v);
    chk("R2 default period", n, 32768);
    chk("R2 counter advance", v, 32'hCAFE_0001);

    // R3 plain divider, upper bits dropped
    bus_write(0, 8'h08, 32'hFF00_0003);
    bus_read(0, 8'h08, r); chk("R3 upper bits", r, 32'h0000_0003);
    measure_period(n, v); chk("R3 period D=3 first", n, 4); chk("R3 count", v, 32'hCAFE_0002);
    measure_period(n, v); chk("R3 period D=3 second", n, 4); chk("R3 count", v, 32'hCAFE_0003);
    bus_write(0, 8'h08, 32'h0000_0009);
    measure_period(n, v); chk("R3 period D=9", n, 10);

    // R4 trim 2 on divider 3
    bus_write(0, 8'h08, 32'h0002_0003);
    measure_period(n, v); chk("R4 stretched 1", n, 5);
    measure_period(n, v); chk("R4 stretched 2", n, 5);
    measure_period(n, v); chk("R4 normal 3", n, 4);
    measure_period(n, v); chk("R4 normal 4", n, 4);

    // R7 / R9 / R8 tick flag with slow divider
    bus_write(0, 8'h10, 32'h0000_0003);
    bus_write(0, 8'h08, 32'd999);
    measure_period(n, v); chk("R3 period D=999", n, 1000);
    bus_read(0, 8'h10, r); chk("R7 tick flag set while disabled", r & 32'h2, 32'h2);
    chk("R9 irq_tick gated", {31'h0, irq_hz_main}, 32'h0);
    bus_write(0, 8'h10, 32'h0000_0008);
    bus_read(0, 8'h10, r); chk("R8 zero write keeps flag", r & 32'hA, 32'hA);
    chk("R9 irq_tick on", {31'h0, irq_hz_main}, 32'h1);
    bus_write(0, 8'h10, 32'h0000_000A);
    bus_read(0, 8'h10, r); chk("R8 one write clears flag", r & 32'h2, 32'h0);
    chk("R9 irq_tick off", {31'h0, irq_hz_main}, 32'h0);

    // R6 alarm compare
    bus_read(0, 8'h04, c);
    bus_write(0, 8'h00, c);
    bus_read(0, 8'h10, r); chk("R6 alarm write alone", r & 32'h1, 32'h0);
    bus_write(0, 8'h00, c + 32'd2);
    measure_period(n, v); chk("R6 count c+1", v, c + 32'd1);
    measure_period(n, v); chk("R6 count c+2", v, c + 32'd2);
    bus_read(0, 8'h10, r); chk("R6 flag not yet", r & 32'h1, 32'h0);
    @(negedge clk);
    bus_read(0, 8'h10, r); chk("R6 flag one cycle later", r & 32'h1, 32'h1);
    chk("R9 irq_alarm gated", {31'h0, irq_al_main}, 32'h0);
    bus_write(0, 8'h10, 32'h0000_0004);
    chk("R9 irq_alarm on", {31'h0, irq_al_main}, 32'h1);
    bus_write(0, 8'h10, 32'h0000_0005);
    bus_read(0, 8'h10, r); chk("R8 alarm flag cleared", r & 32'h1, 32'h0);
    chk("R9 irq_alarm off", {31'h0, irq_al_main}, 32'h0);
    repeat (2) @(negedge clk);
    bus_read(0, 8'h10, r); chk("R6 no re-set while equal", r & 32'h1, 32'h0);

    // R5 counter write coinciding with a tick
    bus_write(0, 8'h08, 32'h0000_0003);
    repeat (3) @(negedge clk);
    bus_write(0, 8'h04, 32'h0000_0100);
    bus_read(0, 8'h04, r); chk("R5 write wins over tick", r, 32'h0000_0100);
    measure_period(n, v); chk("R5 tick timing kept", n, 4); chk("R5 count after", v, 32'h0000_0101);

    // R8 set and clear in the same cycle
    bus_write(0, 8'h10, 32'h0000_0002);
    bus_read(0, 8'h10, r); chk("R8 cleared before tick", r & 32'h2, 32'h0);
    repeat (2) @(negedge clk);
    bus_write(0, 8'h10, 32'h0000_0002);
    bus_read(0, 8'h10, r); chk("R8 set wins over clear", r & 32'h2, 32'h2);

    // R10 alternate layout
    @(negedge clk);
    bus_write(1, 8'h0C, 32'd60000);
    bus_read(1, 8'h0C, r); chk("R10 alt prescaler", r, 32'd60000);
    bus_write(1, 8'h00, 32'h0BAD_F00D);
    bus_read(1, 8'h00, r); chk("R10 alt counter", r, 32'h0BAD_F00D);
    bus_write(1, 8'h04, 32'h0000_5555);
    bus_read(1, 8'h04, r); chk("R10 alt alarm", r, 32'h0000_5555);
    bus_write(1, 8'h08, 32'h0000_000F);
    bus_read(1, 8'h08, r); chk("R10 alt status", r, 32'h0000_000C);
    bus_read(1, 8'h10, r); chk("R10 alt unmapped", r, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule